// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Controller

This block collects the interrupt sources of two serial channels, A and B. Each channel has three sources: receive, transmit and external/status. A per-channel configuration byte enables each source and selects one of four receive interrupt modes. A shared master enable bit gates the single interrupt request line.

Event inputs are one-cycle pulses from the channel datapaths. They cover a received character, an overrun, a framing error, an end of frame, a parity error, the transmit buffer going empty, a transmit data write and an external status change. Command pulses clear individual pending flags, and one command re-arms first-character receive mode. The six pending flags form one status byte that can be read through channel A only. A fixed-priority encoder reports the most urgent pending source, so a handler can service it without scanning the byte.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, every pending flag is clear, `irq` is 0, `top_src` is 7, each channel configuration byte is 0x00 and the master enable is 0.
- R2: The receive mode is configuration bits 4:3. In mode 00, characters and special conditions set nothing. In mode 10, every received character sets the channel's receive pending flag one clock after the event.
- R3: In mode 01, only the first character after reset or after a re-arm command (`cmd_rx_rearm`) sets receive pending. Later characters are ignored until the channel is re-armed.
- R4: A special condition is an overrun, a framing error or an end of frame. A parity error is one too when configuration bit 2 is set. In modes 01, 10 and 11, a special condition sets receive pending. In mode 11, plain characters set nothing.
- R5: Transmit pending sets when the buffer goes empty while configuration bit 1 is set. It clears on `cmd_tx_ack` or on `tx_data_wr`.
- R6: Status pending sets on a status change while configuration bit 0 is set. It clears on `cmd_stat_ack`.
- R7: Receive pending is the OR of a character part and a special-condition part. `cmd_rx_ack` clears only the character part, and `cmd_err_rst` clears only the special-condition part.
- R8: With `rd_chan`=0, `pend_rd` is the status byte: bit 5 is A receive, bit 4 A transmit, bit 3 A status, bit 2 B receive, bit 1 B transmit, bit 0 B status, and bits 7:6 are 0. With `rd_chan`=1, `pend_rd` is 0.
- R9: Address 1 writes the configuration byte of the channel selected by `cfg_chan` (0 = A). Address 9 bit 3 is the shared master enable. `irq` is 1 exactly when the master enable is set and any pending flag is set.
- R10: `top_src` is the highest-priority pending source, coded 0 = A receive, 1 = A transmit, 2 = A status, 3 = B receive, 4 = B transmit and 5 = B status, with 0 the most urgent. It is 7 when nothing is pending.
- R11: A set event and a clear command for the same flag in the same cycle leave the flag set.
- R12: Events, commands and configuration of one channel never change the other channel's pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Channel for address 1 writes (0 = A) |
| cfg_addr | input | 4 | Configuration address (1 or 9) |
| cfg_wdata | input | 8 | Configuration write data |
| ev_rx_char | input | 2 | Character received, per channel |
| ev_overrun | input | 2 | Receiver overrun, per channel |
| ev_frame_err | input | 2 | Framing/CRC error, per channel |
| ev_end_frame | input | 2 | End of frame, per channel |
| ev_parity_err | input | 2 | Parity error, per channel |
| ev_tx_empty | input | 2 | Transmit buffer became empty, per channel |
| tx_data_wr | input | 2 | New transmit data written, per channel |
| ev_stat_chg | input | 2 | External/status change, per channel |
| cmd_rx_ack | input | 2 | Clear character part of receive pending |
| cmd_err_rst | input | 2 | Clear special-condition part of receive pending |
| cmd_rx_rearm | input | 2 | Re-arm first-character mode |
| cmd_tx_ack | input | 2 | Clear transmit pending |
| cmd_stat_ack | input | 2 | Clear status pending |
| rd_chan | input | 1 | Channel the status byte is read through |
| irq | output | 1 | Interrupt request |
| pend_rd | output | 8 | Pending status byte read data |
| top_src | output | 3 | Highest-priority pending source, 7 = none |

## Verification
The bench targets the corner cases of first-character mode. A design that never disarms raises an interrupt on every character, and one that ignores the re-arm command goes silent for good. It also checks that a parity error counts only when enabled, so a design that always treats it as a special condition raises spurious receive interrupts. The split clearing of receive pending gets its own test, because a design that clears both parts on a character acknowledge loses a pending error. Same-cycle set and clear is checked too, since a design where clear wins drops an event. Reads through channel B, the master-enable gating and the priority code with several flags pending are checked last, each of which a wrong bit layout or encoder order would break.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int CFG_W       = 8;
  localparam int NUM_CH      = 2;
  localparam int SRC_N       = 3 * NUM_CH;
  localparam int ADDR_W      = 4;
  localparam int ADDR_CHCFG  = 1;
  localparam int ADDR_MASTER = 9;

  // bit positions inside a channel configuration byte
  localparam int BIT_STAT_EN = 0;
  localparam int BIT_TX_EN   = 1;
  localparam int BIT_PAR_SC  = 2;
  localparam int BIT_MODE_LO = 3;
  localparam int BIT_MODE_HI = 4;
  // bit position of the master enable at address 9
  localparam int BIT_MIE     = 3;

  localparam logic [2:0] SRC_NONE = 3'd7;

  typedef enum logic [1:0] {
    RXI_OFF     = 2'b00,
    RXI_FIRST   = 2'b01,
    RXI_ALL     = 2'b10,
    RXI_SC_ONLY = 2'b11
  } rxi_mode_e;

  // pending vector: bit 5 = A rx ... bit 0 = B status; scan from the top
  function automatic logic [2:0] pick_top(input logic [SRC_N-1:0] pv);
    logic [2:0] code;
    code = SRC_NONE;
    for (int k = 0; k < SRC_N; k++) begin
      if (pv[k]) code = 3'(SRC_N - 1 - k);
    end
    return code;
  endfunction

  function automatic logic [CFG_W-1:0] pack_status(input logic [SRC_N-1:0] pv,
                                                   input logic            via_b);
    logic [CFG_W-1:0] b;
    b = '0;
    if (!via_b) b[SRC_N-1:0] = pv;
    return b;
  endfunction

endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ev_rx_char,
  input  logic             ev_overrun,
  input  logic             ev_frame_err,
  input  logic             ev_end_frame,
  input  logic             ev_parity_err,
  input  logic             ev_tx_empty,
  input  logic             tx_data_wr,
  input  logic             ev_stat_chg,
  input  logic             cmd_rx_ack,
  input  logic             cmd_err_rst,
  input  logic             cmd_rx_rearm,
  input  logic             cmd_tx_ack,
  input  logic             cmd_stat_ack,
  output logic             pend_rx,
  output logic             pend_tx,
  output logic             pend_st,
  output logic             sc_evt,
  output logic [CFG_W-1:0] cfg_q
);

  rxi_mode_e rx_mode;
  logic      armed_q;
  logic      char_pend_q, sc_pend_q, tx_pend_q, st_pend_q;
  logic      char_hit, sc_hit, tx_hit, st_hit;

  assign rx_mode = rxi_mode_e'(cfg_q[BIT_MODE_HI:BIT_MODE_LO]);

  assign sc_evt   = ev_overrun | ev_frame_err | ev_end_frame |
                    (ev_parity_err & cfg_q[BIT_PAR_SC]);
  assign char_hit = ev_rx_char &&
                    ((rx_mode == RXI_ALL) || ((rx_mode == RXI_FIRST) && armed_q));
  assign sc_hit   = sc_evt && (rx_mode != RXI_OFF);
  assign tx_hit   = ev_tx_empty & cfg_q[BIT_TX_EN];
  assign st_hit   = ev_stat_chg & cfg_q[BIT_STAT_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_load) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (cmd_rx_rearm) begin
      armed_q <= 1'b1;
    end else if (ev_rx_char && (rx_mode == RXI_FIRST)) begin
      armed_q <= 1'b0;
    end
  end

  // set has priority over clear for every flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_pend_q <= 1'b0;
      sc_pend_q   <= 1'b0;
      tx_pend_q   <= 1'b0;
      st_pend_q   <= 1'b0;
    end else begin
      if (char_hit)                     char_pend_q <= 1'b1;
      else if (cmd_rx_ack)              char_pend_q <= 1'b0;
      if (sc_hit)                       sc_pend_q   <= 1'b1;
      else if (cmd_err_rst)             sc_pend_q   <= 1'b0;
      if (tx_hit)                       tx_pend_q   <= 1'b1;
      else if (cmd_tx_ack || tx_data_wr) tx_pend_q  <= 1'b0;
      if (st_hit)                       st_pend_q   <= 1'b1;
      else if (cmd_stat_ack)            st_pend_q   <= 1'b0;
    end
  end

  assign pend_rx = char_pend_q | sc_pend_q;
  assign pend_tx = tx_pend_q;
  assign pend_st = st_pend_q;

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic [SRC_N-1:0] pend_vec,
  output logic [2:0]       top_src,
  output logic             any_pend
);
  assign top_src  = pick_top(pend_vec);
  assign any_pend = |pend_vec;
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_chan,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [NUM_CH-1:0] ev_rx_char,
  input  logic [NUM_CH-1:0] ev_overrun,
  input  logic [NUM_CH-1:0] ev_frame_err,
  input  logic [NUM_CH-1:0] ev_end_frame,
  input  logic [NUM_CH-1:0] ev_parity_err,
  input  logic [NUM_CH-1:0] ev_tx_empty,
  input  logic [NUM_CH-1:0] tx_data_wr,
  input  logic [NUM_CH-1:0] ev_stat_chg,
  input  logic [NUM_CH-1:0] cmd_rx_ack,
  input  logic [NUM_CH-1:0] cmd_err_rst,
  input  logic [NUM_CH-1:0] cmd_rx_rearm,
  input  logic [NUM_CH-1:0] cmd_tx_ack,
  input  logic [NUM_CH-1:0] cmd_stat_ack,
  input  logic              rd_chan,
  output logic              irq,
  output logic [CFG_W-1:0]  pend_rd,
  output logic [2:0]        top_src
);

  logic                         mie_q;
  logic                         any_pend;
  logic [SRC_N-1:0]             pend_vec;
  logic [NUM_CH-1:0]            sc_evt;
  logic [NUM_CH-1:0][CFG_W-1:0] cfg_q;
  logic [NUM_CH-1:0]            cfg_load;
  logic [NUM_CH-1:0]            p_rx, p_tx, p_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q <= 1'b0;
    end else if (cfg_we && (cfg_addr == ADDR_W'(ADDR_MASTER))) begin
      mie_q <= cfg_wdata[BIT_MIE];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cfg_load[c] = cfg_we && (cfg_addr == ADDR_W'(ADDR_CHCFG)) &&
                         (cfg_chan == c[0]);
    sio_irq_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_load     (cfg_load[c]),
      .cfg_wdata    (cfg_wdata),
      .ev_rx_char   (ev_rx_char[c]),
      .ev_overrun   (ev_overrun[c]),
      .ev_frame_err (ev_frame_err[c]),
      .ev_end_frame (ev_end_frame[c]),
      .ev_parity_err(ev_parity_err[c]),
      .ev_tx_empty  (ev_tx_empty[c]),
      .tx_data_wr   (tx_data_wr[c]),
      .ev_stat_chg  (ev_stat_chg[c]),
      .cmd_rx_ack   (cmd_rx_ack[c]),
      .cmd_err_rst  (cmd_err_rst[c]),
      .cmd_rx_rearm (cmd_rx_rearm[c]),
      .cmd_tx_ack   (cmd_tx_ack[c]),
      .cmd_stat_ack (cmd_stat_ack[c]),
      .pend_rx      (p_rx[c]),
      .pend_tx      (p_tx[c]),
      .pend_st      (p_st[c]),
      .sc_evt       (sc_evt[c]),
      .cfg_q        (cfg_q[c])
    );
    // channel A (c=0) occupies the upper three bits
    assign pend_vec[3*(NUM_CH-1-c)+2] = p_rx[c];
    assign pend_vec[3*(NUM_CH-1-c)+1] = p_tx[c];
    assign pend_vec[3*(NUM_CH-1-c)]   = p_st[c];
  end

  sio_irq_prio u_prio (
    .pend_vec(pend_vec),
    .top_src (top_src),
    .any_pend(any_pend)
  );

  assign irq     = mie_q & any_pend;
  assign pend_rd = pack_status(pend_vec, rd_chan);

endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk
  import sio_irq_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq,
  input logic                         rd_chan,
  input logic [CFG_W-1:0]             pend_rd,
  input logic [2:0]                   top_src,
  input logic [SRC_N-1:0]             pend_vec,
  input logic [NUM_CH-1:0][CFG_W-1:0] cfg_q,
  input logic [NUM_CH-1:0]            sc_evt,
  input logic [NUM_CH-1:0]            ev_tx_empty,
  input logic [NUM_CH-1:0]            ev_stat_chg,
  input logic [NUM_CH-1:0]            cmd_tx_ack,
  input logic [NUM_CH-1:0]            cmd_stat_ack
);

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd[7:6] == 2'b00); // R8

  AST_B_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_chan |-> (pend_rd == '0)); // R8

  AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |-> !irq); // R9

  AST_TOP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec == '0) |-> (top_src == SRC_NONE)); // R10

  AST_TOP_A_RX: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vec[SRC_N-1] |-> (top_src == 3'd0)); // R10

  AST_TX_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_empty[0] && cfg_q[0][BIT_TX_EN]) |=> pend_vec[4]); // R5

  AST_TX_CLR_A: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_ack[0] && !ev_tx_empty[0]) |=> !pend_vec[4]); // R5

  AST_STAT_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stat_ack[1] && !ev_stat_chg[1]) |=> !pend_vec[0]); // R6

  AST_SC_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_evt[0] && (cfg_q[0][BIT_MODE_HI:BIT_MODE_LO] != 2'b00)) |=> pend_vec[5]); // R4

endmodule

bind sio_irq_ctrl sio_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (irq),
  .rd_chan     (rd_chan),
  .pend_rd     (pend_rd),
  .top_src     (top_src),
  .pend_vec    (pend_vec),
  .cfg_q       (cfg_q),
  .sc_evt      (sc_evt),
  .ev_tx_empty (ev_tx_empty),
  .ev_stat_chg (ev_stat_chg),
  .cmd_tx_ack  (cmd_tx_ack),
  .cmd_stat_ack(cmd_stat_ack)
);

// File: tb/test_sio_irq_ctrl.sv
`timescale 1ns/1ps
module test_sio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_chan = 1'b0, rd_chan = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] ev_rx_char = '0, ev_overrun = '0, ev_frame_err = '0, ev_end_frame = '0;
  logic [1:0] ev_parity_err = '0, ev_tx_empty = '0, tx_data_wr = '0, ev_stat_chg = '0;
  logic [1:0] cmd_rx_ack = '0, cmd_err_rst = '0, cmd_rx_rearm = '0;
  logic [1:0] cmd_tx_ack = '0, cmd_stat_ack = '0;
  logic       irq;
  logic [7:0] pend_rd;
  logic [2:0] top_src;

  int checks = 0;
  int failures = 0;
  logic mie_exp = 1'b0;

  always #10 clk = ~clk;

  sio_irq_ctrl i_sio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ev_rx_char(ev_rx_char), .ev_overrun(ev_overrun), .ev_frame_err(ev_frame_err),
    .ev_end_frame(ev_end_frame), .ev_parity_err(ev_parity_err),
    .ev_tx_empty(ev_tx_empty), .tx_data_wr(tx_data_wr), .ev_stat_chg(ev_stat_chg),
    .cmd_rx_ack(cmd_rx_ack), .cmd_err_rst(cmd_err_rst), .cmd_rx_rearm(cmd_rx_rearm),
    .cmd_tx_ack(cmd_tx_ack), .cmd_stat_ack(cmd_stat_ack),
    .rd_chan(rd_chan), .irq(irq), .pend_rd(pend_rd), .top_src(top_src)
  );

  // event bits: 7 char 6 overrun 5 framing 4 end-of-frame 3 parity 2 tx-empty 1 status 0 tx-write
  // command bits: 4 rx-ack 3 err-reset 2 re-arm 1 tx-ack 0 status-ack
  // entry: {req, channel, events, commands, expected status byte}
  localparam int NV = 27;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  1'b0, 8'h80, 5'h00, 8'h20},  // R2 A char in all-chars mode
    {4'd7,  1'b0, 8'h00, 5'h10, 8'h00},  // R7 ack
    {4'd3,  1'b1, 8'h80, 5'h00, 8'h04},  // R3 B first char
    {4'd7,  1'b1, 8'h00, 5'h10, 8'h00},
    {4'd3,  1'b1, 8'h80, 5'h00, 8'h00},  // R3 disarmed
    {4'd3,  1'b1, 8'h00, 5'h04, 8'h00},  // R3 re-arm
    {4'd3,  1'b1, 8'h80, 5'h00, 8'h04},
    {4'd7,  1'b1, 8'h00, 5'h10, 8'h00},
    {4'd4,  1'b1, 8'h08, 5'h00, 8'h00},  // R4 parity not special
    {4'd4,  1'b1, 8'h40, 5'h00, 8'h04},  // R4 overrun in first mode
    {4'd7,  1'b1, 8'h00, 5'h08, 8'h00},
    {4'd5,  1'b0, 8'h04, 5'h00, 8'h10},  // R5
    {4'd5,  1'b0, 8'h01, 5'h00, 8'h00},  // R5 data write clears
    {4'd5,  1'b0, 8'h04, 5'h00, 8'h10},
    {4'd12, 1'b1, 8'h02, 5'h00, 8'h11},  // R12 B status leaves A alone
    {4'd5,  1'b0, 8'h00, 5'h02, 8'h01},
    {4'd6,  1'b1, 8'h00, 5'h01, 8'h00},  // R6
    {4'd4,  1'b0, 8'h10, 5'h00, 8'h20},  // R4 end of frame
    {4'd7,  1'b0, 8'h80, 5'h00, 8'h20},
    {4'd7,  1'b0, 8'h00, 5'h10, 8'h20},  // R7 error part survives ack
    {4'd7,  1'b0, 8'h00, 5'h08, 8'h00},
    {4'd11, 1'b0, 8'h04, 5'h02, 8'h10},  // R11 set beats clear
    {4'd5,  1'b0, 8'h00, 5'h02, 8'h00},
    {4'd11, 1'b0, 8'h02, 5'h01, 8'h08},  // R11
    {4'd5,  1'b1, 8'h04, 5'h00, 8'h0A},
    {4'd6,  1'b0, 8'h00, 5'h01, 8'h02},
    {4'd5,  1'b1, 8'h00, 5'h02, 8'h00}
  };

  function automatic logic [2:0] exp_top(input logic [7:0] b);
    for (int k = 5; k >= 0; k--) if (b[k]) return 3'(5 - k);
    return 3'd7;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [7:0] exp);
    chk(req, pend_rd, exp);
    chk(req, {7'd0, irq}, {7'd0, mie_exp & (|exp)});
    chk(req, {5'd0, top_src}, {5'd0, exp_top(exp)});
  endtask

  task automatic wcfg(input logic ch, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = ch; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic ch, input logic [7:0] ev, input logic [4:0] cm);
    logic [1:0] m;
    @(negedge clk);
    m = ch ? 2'b10 : 2'b01;
    ev_rx_char    = ev[7] ? m : 2'b00;
    ev_overrun    = ev[6] ? m : 2'b00;
    ev_frame_err  = ev[5] ? m : 2'b00;
    ev_end_frame  = ev[4] ? m : 2'b00;
    ev_parity_err = ev[3] ? m : 2'b00;
    ev_tx_empty   = ev[2] ? m : 2'b00;
    ev_stat_chg   = ev[1] ? m : 2'b00;
    tx_data_wr    = ev[0] ? m : 2'b00;
    cmd_rx_ack    = cm[4] ? m : 2'b00;
    cmd_err_rst   = cm[3] ? m : 2'b00;
    cmd_rx_rearm  = cm[2] ? m : 2'b00;
    cmd_tx_ack    = cm[1] ? m : 2'b00;
    cmd_stat_ack  = cm[0] ? m : 2'b00;
    @(negedge clk);
    {ev_rx_char, ev_overrun, ev_frame_err, ev_end_frame, ev_parity_err} = '0;
    {ev_tx_empty, ev_stat_chg, tx_data_wr} = '0;
    {cmd_rx_ack, cmd_err_rst, cmd_rx_rearm, cmd_tx_ack, cmd_stat_ack} = '0;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset", 8'h00);

    wcfg(1'b0, 4'd1, 8'h13);   // A: all chars, tx, status
    wcfg(1'b1, 4'd1, 8'h0B);   // B: first char, tx, status, parity not special
    wcfg(1'b0, 4'd9, 8'h08); mie_exp = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:13], VEC[i][12:8]);
      chk_all($sformatf("R%0d vec%0d", VEC[i][25:22], i), VEC[i][7:0]);
    end

    // R10 priority with two flags, R9 gating, R8 read via B
    step(1'b0, 8'h02, 5'h00);
    step(1'b1, 8'h20, 5'h00);
    chk_all("R10 A status over B rx", 8'h0C);
    rd_chan = 1'b1;
    @(negedge clk);
    chk("R8 read via B", pend_rd, 8'h00);
    rd_chan = 1'b0;
    wcfg(1'b1, 4'd9, 8'h00); mie_exp = 1'b0;
    chk_all("R9 master off", 8'h0C);
    wcfg(1'b0, 4'd9, 8'h08); mie_exp = 1'b1;
    chk_all("R9 master on", 8'h0C);
    step(1'b0, 8'h00, 5'h01);
    step(1'b1, 8'h00, 5'h08);
    chk_all("R6 R7 cleared", 8'h00);

    // R2 mode 00 and tx disabled
    wcfg(1'b0, 4'd1, 8'h00);
    step(1'b0, 8'hC4, 5'h00);
    chk_all("R2 R5 disabled A", 8'h00);
    // R4 mode 11, parity special
    wcfg(1'b0, 4'd1, 8'h1C);
    step(1'b0, 8'h80, 5'h00);
    chk_all("R4 char ignored in special-only", 8'h00);
    step(1'b0, 8'h08, 5'h00);
    chk_all("R4 parity special", 8'h20);
    step(1'b0, 8'h00, 5'h08);
    chk_all("R7 err reset", 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule